// File: doc/BRIEF.md
# Software Reset Unlock Gate

This block protects a software-reset trigger register from stray writes. A register write bus (strobe, address, data) feeds it. Before the trigger register accepts anything, software has to write three key bytes, in a fixed order, to a separate key register. Once the third key lands, the gate opens. The next write to the trigger register uses up that authority. If the value written is FFh, a one-clock reset request goes to the chip reset generator.

The trigger register sits at address E7h and the key register at F7h. The keys are 55h, then AAh, then 5Ah. Writes to any other address may fall between key bytes without harming the sequence. The trigger register holds the last value it accepted. After a reset request it returns to 00h by itself. Its contents and the unlock state are visible on output ports.

Top module: `swrst_gate`

## Requirements
- R1: After reset, `trig_val_o` is 00h, `unlocked_o` is 0 and `sreset_req_o` is 0.
- R2: Key writes of 55h, AAh and 5Ah to address F7h, in that order, set `unlocked_o` to 1 on the clock edge that takes the third key.
- R3: A key write whose value is not the one expected next returns the sequence to its start. If that value is 55h, it counts as a new first key.
- R4: Writes to any address other than F7h do not advance or break the key sequence. While the gate is locked, this includes writes to E7h.
- R5: While `unlocked_o` is 0, writes to E7h leave `trig_val_o` unchanged and raise no reset request.
- R6: While unlocked, a write of FFh to E7h sets `sreset_req_o` high for exactly the one cycle after the edge that takes the write.
- R7: While unlocked, a write of any value from 00h to FEh to E7h is stored in `trig_val_o` and raises no reset request.
- R8: The first write to E7h after unlocking, whatever its value, clears `unlocked_o` on the same edge.
- R9: `trig_val_o` shows FFh while the request is high and returns to 00h on the edge that ends the request.
- R10: A key write while unlocked withdraws the authority. A value of 55h leaves the sequence after its first step; any other value returns it to the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| sreset_req_o | output | 1 | One-cycle chip reset request |
| unlocked_o | output | 1 | Trigger register currently holds write authority |
| trig_val_o | output | 8 | Current contents of the trigger register |

## Verification
The self-clear of the trigger register and a fresh bus write to that register can fall in the same cycle. Software that retries the trigger writes FFh to E7h again in the cycle where the request is high. The bench issues two back-to-back FFh writes to E7h after one unlock. It expects the second write to be blocked, because the authority was used up: the request drops after one cycle, and `trig_val_o` reads 00h rather than FFh.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_K1   = 2'd1,
    SEQ_K2   = 2'd2,
    SEQ_OPEN = 2'd3
  } seq_st_e;
endpackage

// File: rtl/swrst_addr_dec.sv
module swrst_addr_dec #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hF7,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 8'hE7
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output logic              key_wr_o,
  output logic              trig_wr_o
);
  assign key_wr_o  = wr_en_i && (wr_addr_i == KEY_ADDR);
  assign trig_wr_o = wr_en_i && (wr_addr_i == TRIG_ADDR);
endmodule

// File: rtl/swrst_key_seq.sv
module swrst_key_seq
  import swrst_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY0 = 8'h55,
  parameter logic [DATA_W-1:0] KEY1 = 8'hAA,
  parameter logic [DATA_W-1:0] KEY2 = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic              trig_wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              open_o
);
  seq_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_wr_i) begin
      unique case (st_q)
        SEQ_K1:  st_d = (data_i == KEY1) ? SEQ_K2 : SEQ_IDLE;
        SEQ_K2:  st_d = (data_i == KEY2) ? SEQ_OPEN : SEQ_IDLE;
        default: st_d = SEQ_IDLE;
      endcase
      // a mismatching 55h restarts as first key
      if (st_d == SEQ_IDLE && data_i == KEY0) st_d = SEQ_K1;
    end else if (trig_wr_i && st_q == SEQ_OPEN) begin
      st_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEQ_IDLE;
    else         st_q <= st_d;
  end

  assign open_o = (st_q == SEQ_OPEN);
endmodule

// File: rtl/swrst_trig_reg.sv
module swrst_trig_reg #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] TRIG_VAL = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_wr_i,
  input  logic              open_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_o,
  output logic [DATA_W-1:0] val_o
);
  logic grant;
  logic req_q;
  logic [DATA_W-1:0] val_q;

  assign grant = trig_wr_i && open_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      val_q <= '0;
    end else begin
      req_q <= grant && (data_i == TRIG_VAL);
      if (grant)      val_q <= data_i;
      else if (req_q) val_q <= '0;  // self-clear at end of request
    end
  end

  assign req_o = req_q;
  assign val_o = val_q;
endmodule

// File: rtl/swrst_gate.sv
module swrst_gate #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hF7,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 8'hE7,
  parameter logic [DATA_W-1:0] KEY0 = 8'h55,
  parameter logic [DATA_W-1:0] KEY1 = 8'hAA,
  parameter logic [DATA_W-1:0] KEY2 = 8'h5A,
  parameter logic [DATA_W-1:0] TRIG_VAL = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              sreset_req_o,
  output logic              unlocked_o,
  output logic [DATA_W-1:0] trig_val_o
);
  logic key_wr, trig_wr, open;

  swrst_addr_dec #(.ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .TRIG_ADDR(TRIG_ADDR)) u_dec (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .key_wr_o  (key_wr),
    .trig_wr_o (trig_wr)
  );

  swrst_key_seq #(.DATA_W(DATA_W), .KEY0(KEY0), .KEY1(KEY1), .KEY2(KEY2)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_wr_i  (key_wr),
    .trig_wr_i (trig_wr),
    .data_i    (wr_data_i),
    .open_o    (open)
  );

  swrst_trig_reg #(.DATA_W(DATA_W), .TRIG_VAL(TRIG_VAL)) u_trig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_wr_i (trig_wr),
    .open_i    (open),
    .data_i    (wr_data_i),
    .req_o     (sreset_req_o),
    .val_o     (trig_val_o)
  );

  assign unlocked_o = open;
endmodule

// File: rtl/swrst_gate_chk.sv
module swrst_gate_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hF7,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 8'hE7,
  parameter logic [DATA_W-1:0] KEY2 = 8'h5A,
  parameter logic [DATA_W-1:0] TRIG_VAL = 8'hFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              sreset_req_o,
  input logic              unlocked_o,
  input logic [DATA_W-1:0] trig_val_o
);
  logic trig_wr, key_wr;
  assign trig_wr = wr_en_i && (wr_addr_i == TRIG_ADDR);
  assign key_wr  = wr_en_i && (wr_addr_i == KEY_ADDR);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sreset_req_o |=> !sreset_req_o); // R6

  AST_REQ_NEEDS_AUTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sreset_req_o) |-> $past(unlocked_o && trig_wr && wr_data_i == TRIG_VAL)); // R5

  AST_AUTH_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && trig_wr) |=> !unlocked_o); // R8

  AST_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sreset_req_o |=> (trig_val_o == '0)); // R9

  AST_LOCKED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && !sreset_req_o) |=> $stable(trig_val_o)); // R5

  AST_OPEN_ON_KEY3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $past(key_wr && wr_data_i == KEY2)); // R2
endmodule

bind swrst_gate swrst_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR), .TRIG_ADDR(TRIG_ADDR),
  .KEY2(KEY2), .TRIG_VAL(TRIG_VAL)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .sreset_req_o (sreset_req_o),
  .unlocked_o   (unlocked_o),
  .trig_val_o   (trig_val_o)
);

// File: tb/swrst_gate_bench.sv
`timescale 1ns/1ps
module swrst_gate_bench;
  localparam logic [7:0] KA = 8'hF7;
  localparam logic [7:0] TA = 8'hE7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic req, unl;
  logic [7:0] val;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  swrst_gate u_swrst_gate (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .wr_en_i      (wr_en),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .sreset_req_o (req),
    .unlocked_o   (unl),
    .trig_val_o   (val)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the edge that took the write
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(KA, 8'h55); wr(KA, 8'hAA); wr(KA, 8'h5A);
  endtask

  task automatic t_reset();
    chk("R1 trig_val", val, 8'h00);
    chk("R1 unlocked", {7'd0, unl}, 8'd0);
    chk("R1 req", {7'd0, req}, 8'd0);
  endtask

  task automatic t_locked();
    wr(TA, 8'hFF);
    chk("R5 req locked", {7'd0, req}, 8'd0);
    chk("R5 val locked", val, 8'h00);
    wr(TA, 8'h12);
    chk("R5 val locked 12", val, 8'h00);
  endtask

  task automatic t_fire();
    wr(KA, 8'h55); chk("R2 after k1", {7'd0, unl}, 8'd0);
    wr(KA, 8'hAA); chk("R2 after k2", {7'd0, unl}, 8'd0);
    wr(KA, 8'h5A); chk("R2 after k3", {7'd0, unl}, 8'd1);
    wr(TA, 8'hFF);
    chk("R6 req high", {7'd0, req}, 8'd1);
    chk("R9 val FF", val, 8'hFF);
    chk("R8 consumed", {7'd0, unl}, 8'd0);
    idle();
    chk("R6 req low", {7'd0, req}, 8'd0);
    chk("R9 self clear", val, 8'h00);
  endtask

  task automatic t_wrong_key();
    wr(KA, 8'h55); wr(KA, 8'h33); wr(KA, 8'hAA); wr(KA, 8'h5A);
    chk("R3 wrong key", {7'd0, unl}, 8'd0);
    wr(KA, 8'h55); wr(KA, 8'h55); wr(KA, 8'hAA); wr(KA, 8'h5A);
    chk("R3 55 restart", {7'd0, unl}, 8'd1);
    wr(TA, 8'h3C);
    chk("R7 val stored", val, 8'h3C);
    chk("R7 no req", {7'd0, req}, 8'd0);
    chk("R8 consumed by non-FF", {7'd0, unl}, 8'd0);
    wr(TA, 8'hFF);
    chk("R8 second write blocked req", {7'd0, req}, 8'd0);
    chk("R8 second write blocked val", val, 8'h3C);
  endtask

  task automatic t_interleave();
    wr(KA, 8'h55); wr(8'h10, 8'h77); wr(TA, 8'hFF);
    wr(KA, 8'hAA); wr(8'hF0, 8'h5A); wr(KA, 8'h5A);
    chk("R4 interleaved unlock", {7'd0, unl}, 8'd1);
    chk("R4 locked trig ignored", val, 8'h3C);
    wr(KA, 8'h55);
    chk("R10 key while open", {7'd0, unl}, 8'd0);
    wr(KA, 8'hAA); wr(KA, 8'h5A);
    chk("R10 55 counts as first", {7'd0, unl}, 8'd1);
    wr(KA, 8'h99);
    chk("R10 bad key while open", {7'd0, unl}, 8'd0);
    wr(KA, 8'hAA); wr(KA, 8'h5A);
    chk("R10 back to start", {7'd0, unl}, 8'd0);
  endtask

  task automatic t_collide();
    unlock();
    wr(TA, 8'hFF);
    chk("R6 collide req", {7'd0, req}, 8'd1);
    wr(TA, 8'hFF);
    chk("R9 collide clear", val, 8'h00);
    chk("R6 collide no retrigger", {7'd0, req}, 8'd0);
    idle();
    chk("R6 collide stays low", {7'd0, req}, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle();
    t_reset();
    t_locked();
    t_fire();
    t_wrong_key();
    t_interleave();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule